// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block manages a small pool of fixed-size packet buffers, called pages, for a network controller. It records which pages are taken in a bitmap and keeps three ordered lists of page numbers: pages waiting to be transmitted, pages whose transmission has finished, and pages holding received frames. Software drives it through a three-bit command code, together with a page-select value that names the page for the release and enqueue commands.

The receive path requests a page through its own request line. It receives a grant and a page number in the same cycle, and the granted page joins the receive list. A transmit engine drains the transmit list through a valid/ready handshake while transmit is enabled. Each sent page is then either freed at once (auto-release) or placed on the completion list, where an acknowledge input removes it. The block reports the result of the last command-driven allocation, a one-cycle allocation-done pulse, the heads of the completion and receive lists, the pool size and the number of pages in use.

Top module: `page_pool_mmu`

## Requirements
- R1: `cmd_code` is acted on in a cycle where `cmd_wr` is high, with this encoding: 0 does nothing, 1 allocates a page for transmit, 2 resets the allocator, 3 pops the receive list, 4 pops the receive list and frees its head page, 5 frees page `page_sel`, 6 appends `page_sel` to the transmit list, and 7 empties the transmit and completion lists.
- R2: A command allocation takes the lowest-numbered free page. From the clock edge that samples the command, `alloc_result` holds that page number and `alloc_done` is high for one cycle.
- R3: When every page is in use, a command allocation sets `alloc_result` to 0x80 and does not raise `alloc_done`.
- R4: While `alloc_result` is 0x80, the first page that is freed is taken automatically on the next clock edge. `alloc_result` then shows that page and `alloc_done` pulses.
- R5: The reset command frees every page, empties all three lists and sets `alloc_result` to 0.
- R6: `rx_head` and `done_head` read 0x80 when their list is empty. Otherwise they show the page number at the head, zero-extended.
- R7: Appending to a full transmit list has no effect. A sent page goes onto the completion list only if that list is not full.
- R8: With `auto_release` high, a sent page is freed and does not go onto the completion list.
- R9: `pages_used` equals the number of allocated pages, and `page_total` equals the pool size.
- R10: `tx_valid` is high only while `tx_enable` is high and the transmit list is not empty. `tx_page` presents the entries in the order they were appended, and one entry leaves per cycle in which `tx_valid` and `tx_ready` are both high.
- R11: When the receive request and a command allocation arrive in the same cycle, the receive path gets the lowest free page and the command gets the next one. `rx_grant` is high exactly when a page is free and no reset command is present.
- R12: Popping an empty receive list, or freeing a page that is already free, changes nothing.
- R13: Command 7 leaves the bitmap and the receive list unchanged.
- R14: `done_ack` removes the head of the completion list. On an empty list it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| page_sel | input | IW | Page for the release and enqueue commands |
| tx_enable | input | 1 | Permits transmit draining |
| auto_release | input | 1 | Free sent pages instead of completing them |
| rx_req | input | 1 | Receive page request |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_page | output | IW | Page given to the receive path |
| tx_valid | output | 1 | A transmit entry is offered |
| tx_page | output | IW | Page offered for transmit |
| tx_ready | input | 1 | Engine takes the offered entry |
| done_ack | input | 1 | Remove the completion head |
| alloc_result | output | 8 | Last command allocation, 0x80 on failure |
| alloc_done | output | 1 | One-cycle allocation success pulse |
| done_head | output | 8 | Completion list head or 0x80 |
| rx_head | output | 8 | Receive list head or 0x80 |
| page_total | output | CW | Number of pages in the pool |
| pages_used | output | CW | Pages currently allocated |

## Verification
The bench sweeps the allocator from empty to full and one step beyond, then frees pages in scattered orders so the lowest-free choice is tested. A design that scans from the wrong end, or that reuses a page still in use, shows up as a mismatched `alloc_result`. It frees a page while the failure value is pending and expects the automatic retry with its pulse; a design without the retry leaves 0x80 in place. It raises a receive request and a command allocation in the same cycle, which catches a design that hands both requesters the same page. It also fills the transmit and completion lists to their limits, which shows a design that overwrites entries, loses their order, or still fills the completion list when auto-release is on.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_POP   = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_RELEASE  = 3'd5,
        OP_TX_PUSH  = 3'd6,
        OP_TX_CLEAR = 3'd7
    } mmu_op_e;

    localparam logic [7:0] NO_PAGE = 8'h80;

endpackage

// File: rtl/free_pick.sv
module free_pick #(
    parameter int PAGES = 4,
    localparam int IW = $clog2(PAGES)
) (
    input  logic [PAGES-1:0] busy,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/page_map.sv
module page_map #(
    parameter int PAGES = 4,
    localparam int CW = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PAGES-1:0] set_mask,
    input  logic [PAGES-1:0] free_mask,
    output logic [PAGES-1:0] map_q,
    output logic [CW-1:0]    used
);
    logic [PAGES-1:0] map_d;

    always_comb begin
        map_d = (map_q & ~free_mask) | set_mask;
        if (clr) begin
            map_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < PAGES; i++) begin
            used = used + CW'(map_q[i]);
        end
    end

    // a page granted this cycle must have been free before the grant
    assert_set_was_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask & map_q) == '0));
endmodule

// File: rtl/page_fifo.sv
module page_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_val,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic          do_pop, do_push;
    logic [CW-1:0] wr_at;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt < CW'(DEPTH));
        wr_at   = do_pop ? st_q.cnt - CW'(1) : st_q.cnt;
        if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.ent[DEPTH-1] = '0;
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (do_push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == wr_at) begin
                    st_d.ent[i] = push_val;
                end
            end
            st_d.cnt = st_d.cnt + CW'(1);
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.ent[0];
    assign count = st_q.cnt;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt <= CW'(DEPTH)));

    assert_full_push_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && st_q.cnt == CW'(DEPTH)) |=> (st_q.cnt == CW'(DEPTH)));

    assert_empty_pop_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && st_q.cnt == '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/page_pool_mmu.sv
module page_pool_mmu
    import ppa_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int IW = $clog2(PAGES),
    localparam int CW = $clog2(PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [2:0]    cmd_code,
    input  logic [IW-1:0] page_sel,
    input  logic          tx_enable,
    input  logic          auto_release,
    input  logic          rx_req,
    output logic          rx_grant,
    output logic [IW-1:0] rx_page,
    output logic          tx_valid,
    output logic [IW-1:0] tx_page,
    input  logic          tx_ready,
    input  logic          done_ack,
    output logic [7:0]    alloc_result,
    output logic          alloc_done,
    output logic [7:0]    done_head,
    output logic [7:0]    rx_head,
    output logic [CW-1:0] page_total,
    output logic [CW-1:0] pages_used
);
    typedef struct packed {
        logic [7:0] res;
        logic       done;
    } core_st_t;

    core_st_t core_d, core_q;

    mmu_op_e          op;
    logic             op_alloc, op_reset, op_rx_pop, op_rx_free;
    logic             op_release, op_tx_push, op_tx_clear;
    logic [PAGES-1:0] map_q, set_mask, free_mask, busy_cmd, rx_mask;
    logic             free0, free1, want_alloc, alloc_ok, tx_fire;
    logic [IW-1:0]    pick0, pick1;
    logic [IW-1:0]    rx_head_pg, dn_head_pg;
    logic [CW-1:0]    tx_cnt, dn_cnt, rx_cnt;

    assign op          = mmu_op_e'(cmd_code);
    assign op_alloc    = cmd_wr && (op == OP_ALLOC);
    assign op_reset    = cmd_wr && (op == OP_RESET);
    assign op_rx_pop   = cmd_wr && (op == OP_RX_POP);
    assign op_rx_free  = cmd_wr && (op == OP_RX_FREE);
    assign op_release  = cmd_wr && (op == OP_RELEASE);
    assign op_tx_push  = cmd_wr && (op == OP_TX_PUSH);
    assign op_tx_clear = cmd_wr && (op == OP_TX_CLEAR);

    // receive path picks first, the command path picks from what is left
    free_pick #(.PAGES(PAGES)) i_pick_rx (
        .busy (map_q),
        .found(free0),
        .idx  (pick0)
    );

    assign rx_grant = rx_req && free0 && !op_reset;
    assign rx_page  = pick0;
    assign rx_mask  = rx_grant ? (PAGES'(1) << pick0) : '0;
    assign busy_cmd = map_q | rx_mask;

    free_pick #(.PAGES(PAGES)) i_pick_cmd (
        .busy (busy_cmd),
        .found(free1),
        .idx  (pick1)
    );

    assign want_alloc = !op_reset && (op_alloc || (core_q.res == NO_PAGE));
    assign alloc_ok   = want_alloc && free1;

    assign tx_valid = tx_enable && (tx_cnt != '0);
    assign tx_fire  = tx_valid && tx_ready;

    always_comb begin
        set_mask = rx_mask;
        if (alloc_ok) begin
            set_mask = set_mask | (PAGES'(1) << pick1);
        end
        free_mask = '0;
        if (op_rx_free && rx_cnt != '0) begin
            free_mask = free_mask | (PAGES'(1) << rx_head_pg);
        end
        if (op_release) begin
            free_mask = free_mask | (PAGES'(1) << page_sel);
        end
        if (tx_fire && auto_release) begin
            free_mask = free_mask | (PAGES'(1) << tx_page);
        end
    end

    always_comb begin
        core_d      = core_q;
        core_d.done = alloc_ok;
        if (op_reset) begin
            core_d.res = 8'h00;
        end else if (alloc_ok) begin
            core_d.res = 8'(pick1);
        end else if (op_alloc) begin
            core_d.res = NO_PAGE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    page_map #(.PAGES(PAGES)) i_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (op_reset),
        .set_mask (set_mask),
        .free_mask(free_mask),
        .map_q    (map_q),
        .used     (pages_used)
    );

    page_fifo #(.DEPTH(PAGES), .W(IW)) i_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (op_reset || op_tx_clear),
        .push    (op_tx_push),
        .push_val(page_sel),
        .pop     (tx_fire),
        .head    (tx_page),
        .count   (tx_cnt)
    );

    page_fifo #(.DEPTH(PAGES), .W(IW)) i_doneq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (op_reset || op_tx_clear),
        .push    (tx_fire && !auto_release),
        .push_val(tx_page),
        .pop     (done_ack),
        .head    (dn_head_pg),
        .count   (dn_cnt)
    );

    page_fifo #(.DEPTH(PAGES), .W(IW)) i_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (op_reset),
        .push    (rx_grant),
        .push_val(pick0),
        .pop     (op_rx_pop || op_rx_free),
        .head    (rx_head_pg),
        .count   (rx_cnt)
    );

    assign alloc_result = core_q.res;
    assign alloc_done   = core_q.done;
    assign done_head    = (dn_cnt == '0) ? NO_PAGE : 8'(dn_head_pg);
    assign rx_head      = (rx_cnt == '0) ? NO_PAGE : 8'(rx_head_pg);
    assign page_total   = CW'(PAGES);

    assert_full_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_alloc && pages_used == CW'(PAGES)) |=> (alloc_result == NO_PAGE && !alloc_done));

    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_reset |=> (pages_used == '0 && alloc_result == 8'h00
                      && rx_head == NO_PAGE && done_head == NO_PAGE));

    assert_done_has_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> (pages_used != '0 && alloc_result != NO_PAGE));

    assert_tx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_enable);

    assert_used_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pages_used <= CW'(PAGES)));

    assert_grant_needs_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant |-> (pages_used < CW'(PAGES)));
endmodule

// File: tb/test_page_pool_mmu.sv
module test_page_pool_mmu;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [2:0] cmd_code = '0;
    logic [1:0] page_sel = '0;
    logic       tx_enable = 1'b0, auto_release = 1'b0, rx_req = 1'b0;
    logic       tx_ready = 1'b0, done_ack = 1'b0;
    logic       rx_grant, tx_valid, alloc_done;
    logic [1:0] rx_page, tx_page;
    logic [7:0] alloc_result, done_head, rx_head;
    logic [2:0] page_total, pages_used;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit [NP-1:0] m_bm;
    int m_res;
    int m_tx[$];
    int m_dn[$];
    int m_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_pool_mmu #(.PAGES(NP)) i_page_pool_mmu (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .page_sel(page_sel), .tx_enable(tx_enable), .auto_release(auto_release),
        .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
        .tx_valid(tx_valid), .tx_page(tx_page), .tx_ready(tx_ready),
        .done_ack(done_ack), .alloc_result(alloc_result), .alloc_done(alloc_done),
        .done_head(done_head), .rx_head(rx_head), .page_total(page_total),
        .pages_used(pages_used)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowfree(bit [NP-1:0] b);
        for (int i = 0; i < NP; i++) if (!b[i]) return i;
        return -1;
    endfunction

    function automatic int popc(bit [NP-1:0] b);
        int n = 0;
        for (int i = 0; i < NP; i++) n += int'(b[i]);
        return n;
    endfunction

    task automatic compare_state(string req);
        chk({req, " R9 used"}, int'(pages_used), popc(m_bm));
        chk({req, " R2 result"}, int'(alloc_result), m_res);
        chk({req, " R6 rx_head"}, int'(rx_head), (m_rx.size() == 0) ? 128 : m_rx[0]);
        chk({req, " R6 done_head"}, int'(done_head), (m_dn.size() == 0) ? 128 : m_dn[0]);
    endtask

    // command, then one idle cycle so any automatic retry settles
    task automatic do_cmd(int code, int pg, string req);
        bit e1 = 0, e2 = 0;
        int lf, p;
        bit d1, d2;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_code = 3'(code); page_sel = 2'(pg);
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 1'b0; d1 = alloc_done;
        @(posedge clk);
        @(negedge clk);
        d2 = alloc_done;
        case (code)
            1: begin
                lf = lowfree(m_bm);
                if (lf >= 0) begin m_res = lf; m_bm[lf] = 1; e1 = 1; end
                else m_res = 128;
            end
            2: begin m_bm = '0; m_tx.delete(); m_dn.delete(); m_rx.delete(); m_res = 0; end
            3: if (m_rx.size() > 0) void'(m_rx.pop_front());
            4: if (m_rx.size() > 0) begin p = m_rx.pop_front(); m_bm[p] = 0; end
            5: m_bm[pg] = 0;
            6: if (m_tx.size() < NP) m_tx.push_back(pg);
            7: begin m_tx.delete(); m_dn.delete(); end
            default: ;
        endcase
        lf = lowfree(m_bm);
        if (m_res == 128 && lf >= 0) begin m_res = lf; m_bm[lf] = 1; e2 = 1; end
        chk({req, " R2 done pulse"}, int'(d1), int'(e1));
        chk({req, " R4 retry pulse"}, int'(d2), int'(e2));
        compare_state(req);
    endtask

    task automatic rx_one(string req);
        int lf = lowfree(m_bm);
        @(negedge clk);
        rx_req = 1'b1;
        #1;
        chk({req, " R11 grant"}, int'(rx_grant), int'(lf >= 0));
        if (lf >= 0) chk({req, " R11 page"}, int'(rx_page), lf);
        @(posedge clk);
        @(negedge clk);
        rx_req = 1'b0;
        if (lf >= 0) begin m_bm[lf] = 1; m_rx.push_back(lf); end
        compare_state(req);
    endtask

    task automatic drain(int cycles, bit autor, string req);
        int p;
        @(negedge clk);
        tx_enable = 1'b1; tx_ready = 1'b1; auto_release = autor;
        for (int c = 0; c < cycles; c++) begin
            #1;
            chk({req, " R10 valid"}, int'(tx_valid), int'(m_tx.size() > 0));
            if (m_tx.size() > 0) chk({req, " R10 order"}, int'(tx_page), m_tx[0]);
            @(posedge clk);
            if (m_tx.size() > 0) begin
                p = m_tx.pop_front();
                if (autor) m_bm[p] = 0;
                else if (m_dn.size() < NP) m_dn.push_back(p);
            end
            @(negedge clk);
        end
        tx_enable = 1'b0; tx_ready = 1'b0; auto_release = 1'b0;
        #1;
        compare_state(req);
    endtask

    task automatic ack_one(string req);
        @(negedge clk);
        done_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_ack = 1'b0;
        if (m_dn.size() > 0) void'(m_dn.pop_front());
        compare_state(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_bm = '0; m_res = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        compare_state("reset");
        chk("reset R9 total", int'(page_total), NP);
        chk("reset R2 done", int'(alloc_done), 0);
        chk("reset R10 tx_valid", int'(tx_valid), 0);

        // R2 R3: fill the pool, then one more
        for (int k = 0; k <= NP; k++) do_cmd(1, 0, "R2/R3 sweep");
        // R4: release while failed result is pending
        do_cmd(5, 2, "R4 retry");
        do_cmd(5, 1, "R12 release");
        do_cmd(5, 3, "R12 release");
        do_cmd(5, 3, "R12 double free");
        do_cmd(0, 0, "R1 nop");
        do_cmd(1, 0, "R2 lowest");
        do_cmd(1, 0, "R2 lowest");
        do_cmd(1, 0, "R3 full");
        do_cmd(5, 0, "R4 retry low");

        // R5 then receive path
        do_cmd(2, 0, "R5 reset");
        for (int k = 0; k <= NP; k++) rx_one("R11 rx fill");
        do_cmd(3, 0, "R12 rx pop");
        for (int k = 0; k < 3; k++) do_cmd(4, 0, "R12 rx pop free");
        do_cmd(4, 0, "R12 rx pop free empty");
        do_cmd(3, 0, "R12 rx pop empty");

        // R11 priority
        do_cmd(2, 0, "R5 reset");
        do_cmd(1, 0, "R2 alloc");
        do_cmd(1, 0, "R2 alloc");
        @(negedge clk);
        rx_req = 1'b1; cmd_wr = 1'b1; cmd_code = 3'd1;
        #1;
        chk("R11 prio grant", int'(rx_grant), 1);
        chk("R11 prio rx page", int'(rx_page), 2);
        @(posedge clk);
        @(negedge clk);
        rx_req = 1'b0; cmd_wr = 1'b0;
        chk("R11 prio cmd page", int'(alloc_result), 3);
        chk("R11 prio done", int'(alloc_done), 1);
        m_bm = 4'b1111; m_rx.push_back(2); m_res = 3;
        compare_state("R11 prio");
        do_cmd(1, 0, "R3 full");
        do_cmd(4, 0, "R4 retry via rx free");

        // transmit queue
        do_cmd(2, 0, "R5 reset");
        for (int k = 0; k < NP; k++) do_cmd(1, 0, "R2 alloc");
        do_cmd(6, 3, "R10 push"); do_cmd(6, 1, "R10 push");
        do_cmd(6, 0, "R10 push"); do_cmd(6, 2, "R10 push");
        do_cmd(6, 1, "R7 push full");
        @(negedge clk);
        tx_ready = 1'b1;
        #1;
        chk("R10 disabled valid", int'(tx_valid), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        tx_ready = 1'b0;
        drain(6, 0, "R10 drain");
        do_cmd(6, 1, "R10 push");
        drain(2, 0, "R7 done full");
        for (int k = 0; k <= NP; k++) ack_one("R14 ack");

        // R8 auto release
        do_cmd(6, 0, "R10 push");
        do_cmd(6, 2, "R10 push");
        drain(3, 1, "R8 auto");

        // R13 clear
        do_cmd(6, 1, "R10 push");
        drain(1, 0, "R10 drain one");
        do_cmd(6, 3, "R10 push");
        do_cmd(7, 0, "R13 clear");
        drain(2, 0, "R13 after clear");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule